// File: doc/BRIEF.md
# Upset Monitor with Capture Window

This block watches a stream of 12-bit converter samples that should all equal a fixed reference code, either all ones (4095) or all zeros (0). A sample whose distance from the reference reaches a selectable threshold is an upset. When the monitor is armed, an upset becomes a trigger. The trigger is counted and sorted into two histograms, one by error magnitude and one by the number of flipped bits. A window of samples around the trigger is frozen in a capture buffer that a host can read.

After each window the trigger stays blind for a re-arm period, and upsets in that period are not counted. The block also flags events that persist into the next sample. It marks a window whose pre-trigger samples already held an upset. The run ends once a programmed number of triggers has been counted. All timing is expressed in sample periods (valid samples), derived from nanosecond parameters and the sample rate and rounded up. A single start pulse clears all counters and arms the run.

Top module: `upset_monitor`

## Requirements
- R1: After reset and after each `start` pulse, every counter and histogram bin reads 0, and `done`, `cap_valid`, `cap_multi` and `cap_pre_err` are 0. After `start` the monitor is armed.
- R2: The reference code is 4095 when `cfg_expect_ones`=1 and 0 otherwise. The magnitude is |code − reference|. A sample is an upset when the magnitude is at least 1 (`cfg_thr_ge1`=1) or at least 2 (`cfg_thr_ge1`=0).
- R3: Each counted trigger adds one to the magnitude bin `mag_hist[i*HIST_W +: HIST_W]`. Bin index i is 0, 1, 2, 3, 4 or 5 for a magnitude of 1, 2, 3, 4–7, 8–15 or 16–4095 respectively.
- R4: Each counted trigger adds one to the flipped-bit bin `bits_hist[i*HIST_W +: HIST_W]`. The flipped-bit count is popcount(code XOR reference), and bin index i is 0 to 5 for 1, 2, 3, 4, 5 or 6–12 flipped bits.
- R5: Window lengths are ceil(ns × SAMPLE_HZ / 1e9) samples, at least 1. The defaults give 1 pre-trigger sample, 3 post-trigger samples and 6 re-arm samples. Capture address 0..PRE_N−1 holds the pre-trigger samples, oldest first. Address PRE_N holds the trigger sample, and the post-trigger samples follow in order. `cap_valid` falls on a trigger and rises when the last post-trigger sample is taken.
- R6: Only upsets seen while armed are counted. Upsets during the post-trigger samples and during the REARM_N re-arm samples that follow change no counter. The sample after the re-arm period can trigger again.
- R7: When the first sample after a trigger is also an upset, `multi_count` increments once and `cap_multi` is 1 for that window. The set of flipped bits in that sample may differ from the trigger's.
- R8: `cap_rd_err` gives the upset flag stored with each captured entry. `cap_pre_err` is 1 when any pre-trigger entry of the current window was an upset, for example one left over from the re-arm period.
- R9: When a trigger brings `err_count` to the limit, `done` rises once that trigger's window is complete. After that no counter or capture entry changes until `start`. A limit of 0 selects DEF_LIMIT (100).
- R10: Every counter and bin holds at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear counters and arm a run |
| cfg_expect_ones | input | 1 | Reference code all ones (1) or all zeros (0) |
| cfg_thr_ge1 | input | 1 | Threshold: 1 = magnitude ≥ 1, 0 = magnitude ≥ 2 |
| cfg_err_limit | input | LIM_W | Trigger count that ends the run (0 = DEF_LIMIT) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample code |
| cap_rd_addr | input | ADDR_W (3) | Capture buffer read address |
| cap_rd_data | output | 12 | Captured sample at the read address |
| cap_rd_err | output | 1 | Upset flag of the captured sample |
| cap_valid | output | 1 | A complete window is frozen |
| cap_pre_err | output | 1 | The window's pre-trigger region held an upset |
| cap_multi | output | 1 | The window's event persisted into the next sample |
| err_count | output | LIM_W | Counted triggers |
| multi_count | output | HIST_W | Multi-sample events |
| mag_hist | output | 6×HIST_W | Magnitude histogram, bin i at [i*HIST_W +: HIST_W] |
| bits_hist | output | 6×HIST_W | Flipped-bit histogram, same layout |
| done | output | 1 | Run ended at the limit |

## Verification
A wrong control state appears within one window of about ten samples. An early re-arm adds a count that should not be there. A late re-arm loses a trigger. A stuck post counter keeps `cap_valid` low. A misrouted history entry puts the wrong code or flag at capture address 0. Errors in the classification logic are exposed by sweeping every code under two reference and threshold settings, with both histograms compared at the end of each sweep. The trigger sample is also read back after every window. A second copy of the block with narrow bins runs alongside to show saturation at the bins' maximum value.

// File: rtl/upm_pkg.sv
`timescale 1ns/1ps
package upm_pkg;
    localparam int DATA_W = 12;
    localparam int NBINS  = 6;
    localparam int BIN_W  = 3;
    localparam int POP_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_POST,
        ST_BLIND,
        ST_DONE
    } mon_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic              upset;
    } cap_entry_t;

    typedef struct packed {
        logic             upset;
        logic [BIN_W-1:0] mag_bin;
        logic [BIN_W-1:0] pop_bin;
    } verdict_t;

    // Duration in ns to a whole number of sample periods, rounded up, minimum 1.
    function automatic int ns_to_samples(input longint ns, input longint rate_hz);
        longint n;
        n = (ns * rate_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (n < 1) n = 1;
        return int'(n);
    endfunction

    function automatic logic [BIN_W-1:0] mag_bin_of(input logic [DATA_W-1:0] m);
        if (m >= DATA_W'(16))      return BIN_W'(5);
        else if (m >= DATA_W'(8))  return BIN_W'(4);
        else if (m >= DATA_W'(4))  return BIN_W'(3);
        else if (m >= DATA_W'(3))  return BIN_W'(2);
        else if (m >= DATA_W'(2))  return BIN_W'(1);
        else                       return BIN_W'(0);
    endfunction

    function automatic logic [BIN_W-1:0] pop_bin_of(input logic [POP_W-1:0] n);
        if (n >= POP_W'(6))      return BIN_W'(5);
        else if (n == '0)        return BIN_W'(0);
        else                     return BIN_W'(n - POP_W'(1));
    endfunction
endpackage

// File: rtl/upm_classify.sv
`timescale 1ns/1ps
module upm_classify
    import upm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] code,
    input  logic              expect_ones,
    input  logic              thr_ge1,
    output verdict_t          verdict
);
    logic [DATA_W-1:0] ref_code;
    logic [DATA_W-1:0] flips;
    logic [DATA_W-1:0] mag;
    logic [POP_W-1:0]  nflip;

    always_comb begin
        ref_code        = {DATA_W{expect_ones}};
        flips           = code ^ ref_code;
        mag             = expect_ones ? ~code : code;
        nflip           = POP_W'($countones(flips));
        verdict.upset   = thr_ge1 ? (mag != '0) : (mag > DATA_W'(1));
        verdict.mag_bin = mag_bin_of(mag);
        verdict.pop_bin = pop_bin_of(nflip);
    end

    // R2: an upset always has at least one flipped bit
    a_r2_upset_has_flips: assert property (@(posedge clk) disable iff (rst)
        verdict.upset |-> (nflip != '0));

    // R3: magnitude bin index stays within the six bins
    a_r3_bin_in_range: assert property (@(posedge clk) disable iff (rst)
        verdict.mag_bin <= BIN_W'(NBINS - 1));
endmodule

// File: rtl/upm_bins.sv
`timescale 1ns/1ps
module upm_bins
    import upm_pkg::*;
#(
    parameter int HIST_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    inc,
    input  logic [BIN_W-1:0]        idx,
    output logic [NBINS*HIST_W-1:0] flat
);
    logic [HIST_W-1:0] cnt_q [NBINS];

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q[b] <= '0;
            end else if (inc && idx == BIN_W'(b) && cnt_q[b] != '1) begin
                cnt_q[b] <= cnt_q[b] + 1'b1;
            end
        end
        assign flat[b*HIST_W +: HIST_W] = cnt_q[b];

        // R10: bins never wrap back to a smaller value
        a_r10_bin_no_wrap: assert property (@(posedge clk) disable iff (rst)
            !clr |=> cnt_q[b] >= $past(cnt_q[b]));
    end
endmodule

// File: rtl/upm_capture.sv
`timescale 1ns/1ps
module upm_capture
    import upm_pkg::*;
#(
    parameter int PRE_N  = 1,
    parameter int POST_N = 3,
    parameter int CAP_N  = 5,
    parameter int ADDR_W = 3,
    parameter int PIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic [DATA_W-1:0] code,
    input  logic              upset,
    input  logic              trig,
    input  logic              post_wr,
    input  logic [PIDX_W-1:0] post_idx,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_code,
    output logic              rd_upset,
    output logic              pre_err
);
    cap_entry_t hist_q [PRE_N];
    cap_entry_t cap_q  [CAP_N];
    logic       hist_any;
    cap_entry_t rd_ent;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < PRE_N; i++) hist_q[i] <= '0;
        end else if (shift) begin
            hist_q[0] <= '{code: code, upset: upset};
            for (int i = 1; i < PRE_N; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    always_comb begin
        hist_any = 1'b0;
        for (int i = 0; i < PRE_N; i++) hist_any = hist_any | hist_q[i].upset;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < CAP_N; i++) cap_q[i] <= '0;
            pre_err <= 1'b0;
        end else if (trig) begin
            for (int i = 0; i < PRE_N; i++) cap_q[i] <= hist_q[PRE_N-1-i];
            cap_q[PRE_N] <= '{code: code, upset: 1'b1};
            pre_err      <= hist_any;
        end else if (post_wr) begin
            for (int k = 0; k < POST_N; k++) begin
                if (post_idx == PIDX_W'(k)) cap_q[PRE_N+1+k] <= '{code: code, upset: upset};
            end
        end
    end

    always_comb begin
        rd_ent = '0;
        for (int k = 0; k < CAP_N; k++) begin
            if (rd_addr == ADDR_W'(k)) rd_ent = cap_q[k];
        end
        rd_code  = rd_ent.code;
        rd_upset = rd_ent.upset;
    end

    // R8: the pre-trigger flag can only be raised by a trigger
    a_r8_preflag_from_trig: assert property (@(posedge clk) disable iff (rst)
        $rose(pre_err) |-> $past(trig));
endmodule

// File: rtl/upm_ctrl.sv
`timescale 1ns/1ps
module upm_ctrl
    import upm_pkg::*;
#(
    parameter int POST_N    = 3,
    parameter int REARM_N   = 6,
    parameter int LIM_W     = 16,
    parameter int HIST_W    = 16,
    parameter int DEF_LIMIT = 100,
    parameter int PIDX_W    = 2,
    parameter int BL_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              valid,
    input  logic              upset,
    input  logic [LIM_W-1:0]  limit,
    output logic              trig,
    output logic              post_wr,
    output logic [PIDX_W-1:0] post_idx,
    output logic              shift,
    output logic [LIM_W-1:0]  err_count,
    output logic [HIST_W-1:0] multi_count,
    output logic              cap_valid,
    output logic              cap_multi,
    output logic              done
);
    mon_state_e        state;
    logic [PIDX_W-1:0] post_cnt;
    logic [BL_W-1:0]   blind_cnt;
    logic              done_pend;
    logic [LIM_W-1:0]  eff_limit;
    logic [LIM_W:0]    cnt_next;
    logic              running;

    always_comb begin
        eff_limit = (limit == '0) ? LIM_W'(DEF_LIMIT) : limit;
        cnt_next  = {1'b0, err_count} + 1'b1;
        running   = (state == ST_ARMED) || (state == ST_POST) || (state == ST_BLIND);
        trig      = valid && !start && (state == ST_ARMED) && upset;
        post_wr   = valid && !start && (state == ST_POST);
        shift     = valid && !start && running;
        post_idx  = post_cnt;
        done      = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            post_cnt    <= '0;
            blind_cnt   <= '0;
            done_pend   <= 1'b0;
            err_count   <= '0;
            multi_count <= '0;
            cap_valid   <= 1'b0;
            cap_multi   <= 1'b0;
        end else if (start) begin
            state       <= ST_ARMED;
            post_cnt    <= '0;
            blind_cnt   <= '0;
            done_pend   <= 1'b0;
            err_count   <= '0;
            multi_count <= '0;
            cap_valid   <= 1'b0;
            cap_multi   <= 1'b0;
        end else if (valid) begin
            case (state)
                ST_ARMED: begin
                    if (upset) begin
                        if (err_count != '1) err_count <= err_count + 1'b1;
                        done_pend <= (cnt_next >= {1'b0, eff_limit});
                        state     <= ST_POST;
                        post_cnt  <= '0;
                        cap_valid <= 1'b0;
                        cap_multi <= 1'b0;
                    end
                end
                ST_POST: begin
                    if (post_cnt == '0 && upset) begin
                        if (multi_count != '1) multi_count <= multi_count + 1'b1;
                        cap_multi <= 1'b1;
                    end
                    if (post_cnt == PIDX_W'(POST_N - 1)) begin
                        cap_valid <= 1'b1;
                        blind_cnt <= '0;
                        state     <= done_pend ? ST_DONE : ST_BLIND;
                    end else begin
                        post_cnt <= post_cnt + 1'b1;
                    end
                end
                ST_BLIND: begin
                    if (blind_cnt == BL_W'(REARM_N - 1)) state <= ST_ARMED;
                    else blind_cnt <= blind_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (err_count == '0) && !cap_valid && !done);

    a_r6_blind_no_count: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BLIND && !start) |=> err_count == $past(err_count));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done && (err_count == $past(err_count)));

    a_r7_multi_le_err: assert property (@(posedge clk) disable iff (rst)
        32'(multi_count) <= 32'(err_count));

    a_r5_window_completes_in_post: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_valid) |-> $past(state == ST_POST));
endmodule

// File: rtl/upset_monitor.sv
`timescale 1ns/1ps
module upset_monitor
    import upm_pkg::*;
#(
    parameter longint SAMPLE_HZ = 400_000,
    parameter longint PRE_NS    = 2_500,
    parameter longint POST_NS   = 7_500,
    parameter longint REARM_NS  = 15_000,
    parameter int     LIM_W     = 16,
    parameter int     HIST_W    = 16,
    parameter int     DEF_LIMIT = 100,
    localparam int    PRE_N     = ns_to_samples(PRE_NS, SAMPLE_HZ),
    localparam int    POST_N    = ns_to_samples(POST_NS, SAMPLE_HZ),
    localparam int    REARM_N   = ns_to_samples(REARM_NS, SAMPLE_HZ),
    localparam int    CAP_N     = PRE_N + 1 + POST_N,
    localparam int    ADDR_W    = $clog2(CAP_N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cfg_expect_ones,
    input  logic                    cfg_thr_ge1,
    input  logic [LIM_W-1:0]        cfg_err_limit,
    input  logic                    smp_valid,
    input  logic [DATA_W-1:0]       smp_data,
    input  logic [ADDR_W-1:0]       cap_rd_addr,
    output logic [DATA_W-1:0]       cap_rd_data,
    output logic                    cap_rd_err,
    output logic                    cap_valid,
    output logic                    cap_pre_err,
    output logic                    cap_multi,
    output logic [LIM_W-1:0]        err_count,
    output logic [HIST_W-1:0]       multi_count,
    output logic [NBINS*HIST_W-1:0] mag_hist,
    output logic [NBINS*HIST_W-1:0] bits_hist,
    output logic                    done
);
    localparam int PIDX_W = $clog2(POST_N + 1);
    localparam int BL_W   = $clog2(REARM_N + 1);

    verdict_t          verdict;
    logic              trig;
    logic              post_wr;
    logic [PIDX_W-1:0] post_idx;
    logic              shift;

    upm_classify u_classify (
        .clk         (clk),
        .rst         (rst),
        .code        (smp_data),
        .expect_ones (cfg_expect_ones),
        .thr_ge1     (cfg_thr_ge1),
        .verdict     (verdict)
    );

    upm_ctrl #(
        .POST_N    (POST_N),
        .REARM_N   (REARM_N),
        .LIM_W     (LIM_W),
        .HIST_W    (HIST_W),
        .DEF_LIMIT (DEF_LIMIT),
        .PIDX_W    (PIDX_W),
        .BL_W      (BL_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .valid       (smp_valid),
        .upset       (verdict.upset),
        .limit       (cfg_err_limit),
        .trig        (trig),
        .post_wr     (post_wr),
        .post_idx    (post_idx),
        .shift       (shift),
        .err_count   (err_count),
        .multi_count (multi_count),
        .cap_valid   (cap_valid),
        .cap_multi   (cap_multi),
        .done        (done)
    );

    upm_capture #(
        .PRE_N  (PRE_N),
        .POST_N (POST_N),
        .CAP_N  (CAP_N),
        .ADDR_W (ADDR_W),
        .PIDX_W (PIDX_W)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .clr      (start),
        .shift    (shift),
        .code     (smp_data),
        .upset    (verdict.upset),
        .trig     (trig),
        .post_wr  (post_wr),
        .post_idx (post_idx),
        .rd_addr  (cap_rd_addr),
        .rd_code  (cap_rd_data),
        .rd_upset (cap_rd_err),
        .pre_err  (cap_pre_err)
    );

    upm_bins #(.HIST_W(HIST_W)) u_mag_bins (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .inc  (trig),
        .idx  (verdict.mag_bin),
        .flat (mag_hist)
    );

    upm_bins #(.HIST_W(HIST_W)) u_pop_bins (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .inc  (trig),
        .idx  (verdict.pop_bin),
        .flat (bits_hist)
    );
endmodule

// File: tb/test_upset_monitor.sv
`timescale 1ns/1ps
module test_upset_monitor;
    localparam int HW = 16;
    localparam int SW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        exp_ones = 1'b0;
    logic        thr_ge1 = 1'b1;
    logic [15:0] limit = 16'd0;
    logic        valid = 1'b0;
    logic [11:0] data = 12'd0;
    logic [2:0]  rd_addr = 3'd0;

    logic [11:0]     rd_data_m, rd_data_s;
    logic            rd_err_m, rd_err_s, cv_m, cv_s, pe_m, pe_s, cm_m, cm_s, done_m, done_s;
    logic [15:0]     ec_m, ec_s;
    logic [HW-1:0]   mc_m;
    logic [SW-1:0]   mc_s;
    logic [6*HW-1:0] mh_m, bh_m;
    logic [6*SW-1:0] mh_s, bh_s;

    upset_monitor i_upset_monitor (
        .clk(clk), .rst(rst), .start(start), .cfg_expect_ones(exp_ones),
        .cfg_thr_ge1(thr_ge1), .cfg_err_limit(limit), .smp_valid(valid),
        .smp_data(data), .cap_rd_addr(rd_addr), .cap_rd_data(rd_data_m),
        .cap_rd_err(rd_err_m), .cap_valid(cv_m), .cap_pre_err(pe_m),
        .cap_multi(cm_m), .err_count(ec_m), .multi_count(mc_m),
        .mag_hist(mh_m), .bits_hist(bh_m), .done(done_m)
    );

    upset_monitor #(.HIST_W(SW)) i_upset_monitor_sat (
        .clk(clk), .rst(rst), .start(start), .cfg_expect_ones(exp_ones),
        .cfg_thr_ge1(thr_ge1), .cfg_err_limit(limit), .smp_valid(valid),
        .smp_data(data), .cap_rd_addr(rd_addr), .cap_rd_data(rd_data_s),
        .cap_rd_err(rd_err_s), .cap_valid(cv_s), .cap_pre_err(pe_s),
        .cap_multi(cm_s), .err_count(ec_s), .multi_count(mc_s),
        .mag_hist(mh_s), .bits_hist(bh_s), .done(done_s)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int em[6];
    int eb[6];

    task automatic check(input string tag, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send(input int d);
        @(negedge clk);
        valid = 1'b1;
        data  = 12'(d);
        @(posedge clk);
        #1;
        valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic read_cap(input int a, output int code, output int flag);
        rd_addr = 3'(a);
        #0.1;
        code = int'(rd_data_m);
        flag = int'(rd_err_m);
    endtask

    function automatic int mbin(input int mag);
        if (mag >= 16) return 5;
        if (mag >= 8)  return 4;
        if (mag >= 4)  return 3;
        return mag - 1;
    endfunction

    function automatic int pbin(input int n);
        return (n >= 6) ? 5 : n - 1;
    endfunction

    function automatic int mh(input int i); return int'(mh_m[i*HW +: HW]); endfunction
    function automatic int bh(input int i); return int'(bh_m[i*HW +: HW]); endfunction

    task automatic sweep(input logic ones, input logic ge1, input string tag);
        int refc, mag, nb, c0, f0, lim;
        refc = ones ? 4095 : 0;
        lim  = ge1 ? 1 : 2;
        for (int i = 0; i < 6; i++) begin em[i] = 0; eb[i] = 0; end
        exp_ones = ones; thr_ge1 = ge1; limit = 16'hFFFF;
        pulse_start();
        for (int c = 0; c < 4096; c++) begin
            mag = (c > refc) ? c - refc : refc - c;
            nb  = $countones(12'(c) ^ 12'(refc));
            if (mag >= lim) begin
                em[mbin(mag)]++;
                eb[pbin(nb)]++;
                send(c);
                for (int k = 0; k < 3; k++) send(refc);
                read_cap(1, c0, f0);
                check({tag, " R5 trigger code in slot"}, c0, c);
                for (int k = 0; k < 6; k++) send(refc);
            end else begin
                send(c);
            end
        end
        for (int i = 0; i < 6; i++) begin
            check({tag, " R3 magnitude bin"}, mh(i), em[i]);
            check({tag, " R4 flipped-bit bin"}, bh(i), eb[i]);
            check({tag, " R10 saturated magnitude bin"}, int'(mh_s[i*SW +: SW]), (em[i] > 7) ? 7 : em[i]);
            check({tag, " R10 saturated flipped-bit bin"}, int'(bh_s[i*SW +: SW]), (eb[i] > 7) ? 7 : eb[i]);
        end
        check({tag, " R2 trigger total"}, int'(ec_m), em[0]+em[1]+em[2]+em[3]+em[4]+em[5]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1-timeout actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0, f0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1 err_count after reset", int'(ec_m), 0);
        check("R1 done after reset", int'(done_m), 0);
        check("R1 cap_valid after reset", int'(cv_m), 0);
        check("R1 multi after reset", int'(mc_m), 0);

        // Window layout, blind period, multi-cycle, pre-trigger flag
        exp_ones = 1'b0; thr_ge1 = 1'b1; limit = 16'd0;
        pulse_start();
        send(0);
        check("R6 clean sample not counted", int'(ec_m), 0);
        send(5);
        check("R6 armed trigger counted", int'(ec_m), 1);
        check("R5 cap_valid low after trigger", int'(cv_m), 0);
        send(3);
        check("R7 multi_count", int'(mc_m), 1);
        send(0);
        check("R5 cap_valid low mid window", int'(cv_m), 0);
        send(7);
        check("R5 cap_valid after last post sample", int'(cv_m), 1);
        check("R7 cap_multi", int'(cm_m), 1);
        check("R8 no pre error", int'(pe_m), 0);
        check("R6 post upsets ignored", int'(ec_m), 1);
        read_cap(0, c0, f0); check("R5 slot0 code", c0, 0); check("R8 slot0 flag", f0, 0);
        read_cap(1, c0, f0); check("R5 slot1 code", c0, 5); check("R8 slot1 flag", f0, 1);
        read_cap(2, c0, f0); check("R5 slot2 code", c0, 3); check("R8 slot2 flag", f0, 1);
        read_cap(3, c0, f0); check("R5 slot3 code", c0, 0); check("R8 slot3 flag", f0, 0);
        read_cap(4, c0, f0); check("R5 slot4 code", c0, 7); check("R8 slot4 flag", f0, 1);
        send(9); send(0); send(0); send(0); send(0); send(12);
        check("R6 blind upsets ignored", int'(ec_m), 1);
        send(20);
        check("R6 re-armed after blind", int'(ec_m), 2);
        send(0); send(0); send(0);
        check("R8 pre error flag", int'(pe_m), 1);
        read_cap(0, c0, f0); check("R8 pre slot code", c0, 12); check("R8 pre slot flag", f0, 1);
        check("R7 no multi second window", int'(cm_m), 0);
        check("R7 multi_count held", int'(mc_m), 1);
        check("R3 bin 4-7", mh(3), 1);
        check("R3 bin 16+", mh(5), 1);
        check("R4 two-bit bin", bh(1), 2);
        pulse_start();
        check("R1 err_count after start", int'(ec_m), 0);
        check("R1 cap_valid after start", int'(cv_m), 0);
        check("R1 pre flag after start", int'(pe_m), 0);
        check("R1 bin after start", mh(5), 0);
        check("R1 multi after start", int'(mc_m), 0);

        // Threshold boundaries
        exp_ones = 1'b0; thr_ge1 = 1'b0;
        send(1);
        check("R2 magnitude 1 below >1 threshold", int'(ec_m), 0);
        send(2);
        check("R2 magnitude 2 above >1 threshold", int'(ec_m), 1);
        for (int k = 0; k < 9; k++) send(0);
        exp_ones = 1'b1;
        send(4094);
        check("R2 ones ref magnitude 1 ignored", int'(ec_m), 1);
        thr_ge1 = 1'b1;
        send(4094);
        check("R2 ones ref magnitude 1 counted", int'(ec_m), 2);
        for (int k = 0; k < 9; k++) send(4095);

        // Run limit of 2
        limit = 16'd2;
        pulse_start();
        send(0); for (int k = 0; k < 9; k++) send(4095);
        send(0);
        check("R9 count at limit", int'(ec_m), 2);
        check("R9 not done before window end", int'(done_m), 0);
        send(4095); send(4095);
        check("R9 not done mid window", int'(done_m), 0);
        send(4095);
        check("R9 done after window", int'(done_m), 1);
        send(100); send(0);
        check("R9 count frozen", int'(ec_m), 2);
        check("R9 still done", int'(done_m), 1);
        read_cap(1, c0, f0); check("R9 capture frozen", c0, 0);

        // Default limit via zero
        limit = 16'd0;
        pulse_start();
        for (int t = 0; t < 99; t++) begin
            send(0); for (int k = 0; k < 9; k++) send(4095);
        end
        check("R9 count before default limit", int'(ec_m), 99);
        check("R9 not done before default limit", int'(done_m), 0);
        send(0); send(4095); send(4095); send(4095);
        check("R9 done at default limit", int'(done_m), 1);
        check("R9 count at default limit", int'(ec_m), 100);
        check("R3 full-scale bin", mh(5), 100);
        check("R4 twelve-bit bin", bh(5), 100);
        check("R10 saturated bin", int'(mh_s[5*SW +: SW]), 7);

        // Sweeps over every code
        sweep(1'b1, 1'b1, "ones/ge1");
        sweep(1'b0, 1'b0, "zeros/gt1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule